// File: doc/BRIEF.md
# Tape Controller Register Front End

This block is the processor-facing register set of a magnetic tape controller. Software reaches it over a 16-bit register bus. Bits [3:1] of the bus address pick one of six registers:

- a read-only status word
- a command word
- a count
- a memory address
- an 8-bit data buffer
- a read-lines word

Writes may be full words or single bytes. The block holds the command fields: function, unit, density, parity select, extended address and interrupt enable. It also keeps the done and error indications and drives one interrupt request line.

Data movement and tape motion belong to a separate operation engine. When software writes the command word with the go bit set, the block hands a one-cycle start pulse to that engine, together with the command fields. When the operation ends, the engine returns a one-cycle completion pulse with a set of error flags. This block then raises done, records the flags in the status word and, if interrupt enable is set, requests an interrupt.

Software must wait for done before it issues a new command. A command write that arrives while an operation is still running is refused and is recorded as an illegal-operation flag.

Top module: `tape_ctl_regs`

## Requirements
- R1: After reset the command word reads 0x0080 (only done set), the status word reads 0x0001 (ready), the count, address, data buffer and read-lines registers read 0, and irq is low.
- R2: The register index is bus_addr[3:1]: 0 status, 1 command, 2 count, 3 address, 4 data buffer, 5 read lines. Indices 6 and 7 read as zero. bus_rdata presents the value on the clock edge after the cycle in which bus_rd is high, and holds it until the next read.
- R3: A word write (bus_byte=0) loads all 16 bits. A byte write takes its byte from bus_wdata[7:0]. With bus_addr[0]=1 it replaces bits 15:8; with bus_addr[0]=0 it replaces bits 7:0. The other byte keeps its value.
- R4: Writes to the status word have no effect on it.
- R5: A command write while done is clear changes no command field and sets status bit 15 (illegal).
- R6: An accepted command write whose merged value has bit 12 set resets every register to its R1 state, instead of loading the command.
- R7: An accepted command write with bit 0 (go) set does four things. It pulses eng_go for exactly the next cycle, with eng_func taken from command bits 3:1. It clears done. It clears the status error flags and irq. Bit 0 always reads back as 0.
- R8: A pulse on eng_done sets done, ORs eng_flags[8:0] into status bits 15:7, and raises irq if interrupt enable (command bit 6) is set.
- R9: Command bit 15 (error) reads as 1 exactly when any of status bits 15:7 is set. Status bit 0 (ready) equals done.
- R10: An accepted command write with bit 6 clear drops irq. An accepted write that changes bit 6 from 0 to 1 while done or error is set raises irq. irq is never high while interrupt enable is clear.
- R11: Every read of the read-lines register inverts its bit 15 and returns the inverted value.
- R12: The data buffer keeps only 8 bits, which read back zero-extended. A byte write with bus_addr[0]=1 to the data buffer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_byte | input | 1 | 1 = byte write, 0 = word write |
| bus_addr | input | 4 | Bits 3:1 register index, bit 0 byte lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| eng_go | output | 1 | One-cycle start pulse to the operation engine |
| eng_func | output | 3 | Command function field |
| eng_unit | output | 3 | Command unit field |
| eng_xaddr | output | 2 | Extended address bits |
| eng_dens | output | 2 | Density field |
| eng_par | output | 1 | Parity select |
| eng_count | output | 16 | Count register |
| eng_addr | output | 16 | Memory address register |
| eng_done | input | 1 | Operation complete pulse |
| eng_flags | input | 9 | Error flags for status bits 15:7, valid with eng_done |

## Verification
The bench builds the block with its defaults: an 8-bit data buffer, and the read-lines toggle placed on bit 15. With those values, three things can be checked exactly at the ports:

- The ignored upper-lane write to the data buffer.
- The zero-extension of the data buffer on readback.
- The alternating 0x8000 and 0x0000 pattern of the read lines.

A behavioural model follows the command, done, flags and interrupt state through these sequences:

- a write refused while busy
- an engine completion that carries flags
- an initialise issued through a byte write to the upper command lane
- each way interrupt enable can be turned on and off

// File: rtl/tcr_pkg.sv
package tcr_pkg;

    localparam int WORD_W   = 16;
    localparam int IX_W     = 3;
    localparam int FLAG_W   = 9;              // status bits 15..7
    localparam int ILL_FLAG = FLAG_W - 1;     // maps to status bit 15
    localparam int PAD_W    = WORD_W - FLAG_W - 1;

    // command bit positions (decoded by software and the engine)
    localparam int CB_GO    = 0;
    localparam int CB_FUNC  = 1;
    localparam int CB_XADDR = 4;
    localparam int CB_IE    = 6;
    localparam int CB_DONE  = 7;
    localparam int CB_UNIT  = 8;
    localparam int CB_PAR   = 11;
    localparam int CB_INIT  = 12;
    localparam int CB_DENS  = 13;
    localparam int CB_ERR   = 15;

    localparam logic [WORD_W-1:0] CMD_RW_MASK = 16'h6F7E;
    localparam logic [WORD_W-1:0] CMD_RESET   = 16'h0080;
    localparam logic [WORD_W-1:0] ERR_MASK    = 16'h8000;

    typedef enum logic [IX_W-1:0] {
        IX_STAT = 3'd0,
        IX_CMD  = 3'd1,
        IX_CNT  = 3'd2,
        IX_ADR  = 3'd3,
        IX_DBUF = 3'd4,
        IX_RLIN = 3'd5
    } reg_ix_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              bytew;
        logic              hi;
        logic [IX_W-1:0]   ix;
        logic [WORD_W-1:0] wd;
    } bus_req_t;

    // merge a bus write into a current register value
    function automatic logic [WORD_W-1:0] merge_word(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wd,
        input logic              bytew,
        input logic              hi
    );
        logic [WORD_W-1:0] r;
        if (!bytew)  r = wd;
        else if (hi) r = {wd[7:0], cur[7:0]};
        else         r = {cur[15:8], wd[7:0]};
        return r;
    endfunction

endpackage

// File: rtl/tcr_cmd_ctl.sv
module tcr_cmd_ctl
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              eng_done,
    input  logic [FLAG_W-1:0] eng_flags,
    output logic              init_hit,
    output logic              go,
    output logic              irq,
    output logic              done_q,
    output logic              ie_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] stat_word
);

    logic [WORD_W-1:0] cmd_n;
    logic [WORD_W-1:0] merged;
    logic [FLAG_W-1:0] flags_n;
    logic              irq_n;
    logic              go_n;
    logic              hit;
    logic              err;

    assign hit      = req.wr && (req.ix == IX_CMD);
    assign err      = |flags_q;
    assign done_q   = cmd_q[CB_DONE];
    assign ie_q     = cmd_q[CB_IE];
    assign merged   = merge_word(cmd_word, req.wd, req.bytew, req.hi);
    assign init_hit = hit && done_q && merged[CB_INIT];

    assign cmd_word  = cmd_q | (err ? ERR_MASK : '0);
    assign stat_word = {flags_q, {PAD_W{1'b0}}, done_q};

    always_comb begin
        cmd_n   = cmd_q;
        flags_n = flags_q;
        irq_n   = irq;
        go_n    = 1'b0;
        if (eng_done) begin
            cmd_n[CB_DONE] = 1'b1;
            flags_n        = flags_n | eng_flags;
            if (ie_q) irq_n = 1'b1;
        end
        if (hit) begin
            if (!done_q) begin
                flags_n[ILL_FLAG] = 1'b1;
            end else begin
                if (!merged[CB_IE])
                    irq_n = 1'b0;
                else if ((done_q || err) && !ie_q)
                    irq_n = 1'b1;
                cmd_n = (cmd_n & ~CMD_RW_MASK) | (merged & CMD_RW_MASK);
                if (merged[CB_GO]) begin
                    cmd_n[CB_DONE] = 1'b0;
                    flags_n        = '0;
                    irq_n          = 1'b0;
                    go_n           = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init_hit) begin
            cmd_q   <= CMD_RESET;
            flags_q <= '0;
            irq     <= 1'b0;
            go      <= 1'b0;
        end else begin
            cmd_q   <= cmd_n;
            flags_q <= flags_n;
            irq     <= irq_n;
            go      <= go_n;
        end
    end

endmodule

// File: rtl/tcr_aux_regs.sv
module tcr_aux_regs
    import tcr_pkg::*;
#(
    parameter int DB_W   = 8,
    parameter int RL_BIT = 15
) (
    input  logic              clk,
    input  logic              srst,
    input  bus_req_t          req,
    output logic [WORD_W-1:0] cnt_q,
    output logic [WORD_W-1:0] adr_q,
    output logic [DB_W-1:0]   db_q,
    output logic [WORD_W-1:0] rl_q
);

    localparam logic [WORD_W-1:0] RL_TICK = WORD_W'(1) << RL_BIT;

    always_ff @(posedge clk) begin
        if (srst) begin
            cnt_q <= '0;
            adr_q <= '0;
            db_q  <= '0;
            rl_q  <= '0;
        end else begin
            if (req.wr) begin
                case (req.ix)
                    IX_CNT:  cnt_q <= merge_word(cnt_q, req.wd, req.bytew, req.hi);
                    IX_ADR:  adr_q <= merge_word(adr_q, req.wd, req.bytew, req.hi);
                    IX_DBUF: begin
                        if (!req.bytew)
                            db_q <= req.wd[DB_W-1:0];
                        else if (!req.hi)
                            db_q[7:0] <= req.wd[7:0];
                    end
                    default: ;
                endcase
            end
            if (req.rd && (req.ix == IX_RLIN))
                rl_q <= rl_q ^ RL_TICK;
        end
    end

endmodule

// File: rtl/tcr_rd_mux.sv
module tcr_rd_mux
    import tcr_pkg::*;
#(
    parameter int DB_W   = 8,
    parameter int RL_BIT = 15
) (
    input  logic              clk,
    input  logic              srst,
    input  bus_req_t          req,
    input  logic [WORD_W-1:0] stat_word,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [WORD_W-1:0] cnt_q,
    input  logic [WORD_W-1:0] adr_q,
    input  logic [DB_W-1:0]   db_q,
    input  logic [WORD_W-1:0] rl_q,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [WORD_W-1:0] RL_TICK = WORD_W'(1) << RL_BIT;

    logic [WORD_W-1:0] sel;

    always_comb begin
        case (req.ix)
            IX_STAT: sel = stat_word;
            IX_CMD:  sel = cmd_word;
            IX_CNT:  sel = cnt_q;
            IX_ADR:  sel = adr_q;
            IX_DBUF: sel = WORD_W'(db_q);
            IX_RLIN: sel = rl_q ^ RL_TICK;
            default: sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst)        rdata <= '0;
        else if (req.rd) rdata <= sel;
    end

endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
    import tcr_pkg::*;
#(
    parameter int DB_W   = 8,
    parameter int RL_BIT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [3:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq,
    output logic              eng_go,
    output logic [2:0]        eng_func,
    output logic [2:0]        eng_unit,
    output logic [1:0]        eng_xaddr,
    output logic [1:0]        eng_dens,
    output logic              eng_par,
    output logic [15:0]       eng_count,
    output logic [15:0]       eng_addr,
    input  logic              eng_done,
    input  logic [8:0]        eng_flags
);

    bus_req_t          req;
    logic              init_hit;
    logic              srst;
    logic              done_q;
    logic              ie_q;
    logic [FLAG_W-1:0] flags_q;
    logic [WORD_W-1:0] cmd_q;
    logic [WORD_W-1:0] cmd_word;
    logic [WORD_W-1:0] stat_word;
    logic [WORD_W-1:0] rl_q;
    logic [DB_W-1:0]   db_q;

    assign req = '{rd: bus_rd, wr: bus_wr, bytew: bus_byte, hi: bus_addr[0],
                   ix: bus_addr[3:1], wd: bus_wdata};
    assign srst = rst || init_hit;

    tcr_cmd_ctl u_cmd (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .eng_done  (eng_done),
        .eng_flags (eng_flags),
        .init_hit  (init_hit),
        .go        (eng_go),
        .irq       (irq),
        .done_q    (done_q),
        .ie_q      (ie_q),
        .flags_q   (flags_q),
        .cmd_q     (cmd_q),
        .cmd_word  (cmd_word),
        .stat_word (stat_word)
    );

    tcr_aux_regs #(.DB_W(DB_W), .RL_BIT(RL_BIT)) u_aux (
        .clk   (clk),
        .srst  (srst),
        .req   (req),
        .cnt_q (eng_count),
        .adr_q (eng_addr),
        .db_q  (db_q),
        .rl_q  (rl_q)
    );

    tcr_rd_mux #(.DB_W(DB_W), .RL_BIT(RL_BIT)) u_rd (
        .clk       (clk),
        .srst      (srst),
        .req       (req),
        .stat_word (stat_word),
        .cmd_word  (cmd_word),
        .cnt_q     (eng_count),
        .adr_q     (eng_addr),
        .db_q      (db_q),
        .rl_q      (rl_q),
        .rdata     (bus_rdata)
    );

    assign eng_func  = cmd_q[CB_FUNC +: 3];
    assign eng_unit  = cmd_q[CB_UNIT +: 3];
    assign eng_xaddr = cmd_q[CB_XADDR +: 2];
    assign eng_dens  = cmd_q[CB_DENS +: 2];
    assign eng_par   = cmd_q[CB_PAR];

endmodule

// File: rtl/tcr_chk.sv
module tcr_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [2:0] bus_ix,
    input logic [15:0] bus_rdata,
    input logic       irq,
    input logic       eng_go,
    input logic       eng_done,
    input logic       done_q,
    input logic       ie_q,
    input logic [8:0] flags_q
);

    // R10
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie_q);

    // R7
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_go |=> !eng_go);

    // R7
    go_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eng_go |-> (!done_q && !irq));

    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !bus_wr) |=> done_q);

    // R2
    hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_ix >= 3'd6) |=> (bus_rdata == 16'h0000));

    // R5
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_ix == 3'd1 && !done_q) |=> flags_q[8]);

    // R4
    stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_ix == 3'd0 && !eng_done) |=> $stable(flags_q));

endmodule

bind tape_ctl_regs tcr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_ix    (bus_addr[3:1]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .eng_go    (eng_go),
    .eng_done  (eng_done),
    .done_q    (done_q),
    .ie_q      (ie_q),
    .flags_q   (flags_q)
);

// File: tb/sim_tape_ctl_regs.sv
`timescale 1ns/1ps
module sim_tape_ctl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd = 1'b0, wr = 1'b0, bw = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wd = 16'd0;
    logic        done_in = 1'b0;
    logic [8:0]  fl_in = 9'd0;

    logic [15:0] rdata, cnt_o, adr_o;
    logic        irq, go;
    logic [2:0]  func, unit;
    logic [1:0]  xaddr, dens;
    logic        par;

    always #2 clk = ~clk;

    tape_ctl_regs u0 (
        .clk(clk), .rst(rst), .bus_rd(rd), .bus_wr(wr), .bus_byte(bw),
        .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata), .irq(irq),
        .eng_go(go), .eng_func(func), .eng_unit(unit), .eng_xaddr(xaddr),
        .eng_dens(dens), .eng_par(par), .eng_count(cnt_o), .eng_addr(adr_o),
        .eng_done(done_in), .eng_flags(fl_in)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] m_cmd = 16'h0080;
    logic [8:0]  m_fl = 0;
    logic        m_irq = 0, m_go = 0, m_rl = 0;
    logic [15:0] m_cnt = 0, m_adr = 0, m_rdata = 0;
    logic [7:0]  m_db = 0;

    function automatic logic [15:0] m_merge(input logic [15:0] cur, input logic [15:0] v);
        if (!bw) return v;
        if (addr[0]) return {v[7:0], cur[7:0]};
        return {cur[15:8], v[7:0]};
    endfunction

    function automatic logic [15:0] m_cmdword();
        return m_cmd | ((m_fl != 0) ? 16'h8000 : 16'h0000);
    endfunction

    task automatic m_clear();
        m_cmd = 16'h0080; m_fl = 0; m_irq = 0; m_go = 0; m_rl = 0;
        m_cnt = 0; m_adr = 0; m_db = 0; m_rdata = 0;
    endtask

    always @(posedge clk) begin
        if (rst) m_clear();
        else begin
            logic        odone, oie, oerr;
            logic [15:0] mv;
            odone = m_cmd[7]; oie = m_cmd[6]; oerr = (m_fl != 0);
            m_go = 0;
            if (rd) begin
                case (addr[3:1])
                    3'd0: m_rdata = {m_fl, 6'd0, m_cmd[7]};
                    3'd1: m_rdata = m_cmdword();
                    3'd2: m_rdata = m_cnt;
                    3'd3: m_rdata = m_adr;
                    3'd4: m_rdata = {8'd0, m_db};
                    3'd5: begin m_rl = ~m_rl; m_rdata = {m_rl, 15'd0}; end
                    default: m_rdata = 0;
                endcase
            end
            if (done_in) begin
                m_cmd[7] = 1; m_fl = m_fl | fl_in;
                if (oie) m_irq = 1;
            end
            if (wr) begin
                case (addr[3:1])
                    3'd1: begin
                        if (!odone) m_fl[8] = 1;
                        else begin
                            mv = m_merge(m_cmdword(), wd);
                            if (mv[12]) m_clear();
                            else begin
                                if (!mv[6]) m_irq = 0;
                                else if (!oie && (odone || oerr)) m_irq = 1;
                                m_cmd = (m_cmd & ~16'h6F7E) | (mv & 16'h6F7E);
                                if (mv[0]) begin
                                    m_cmd[7] = 0; m_fl = 0; m_irq = 0; m_go = 1;
                                end
                            end
                        end
                    end
                    3'd2: m_cnt = m_merge(m_cnt, wd);
                    3'd3: m_adr = m_merge(m_adr, wd);
                    3'd4: if (!(bw && addr[0])) m_db = wd[7:0];
                    default: ;
                endcase
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 rdata vs model", rdata, m_rdata);
            chk("R10 irq vs model", {15'd0, irq}, {15'd0, m_irq});
            chk("R7 eng_go vs model", {15'd0, go}, {15'd0, m_go});
        end
    end

    task automatic bus_write(input int ix, input logic [15:0] v, input logic byt, input logic hi);
        @(negedge clk);
        wr = 1; bw = byt; addr = {ix[2:0], hi}; wd = v;
        @(negedge clk);
        wr = 0; bw = 0;
    endtask

    task automatic bus_read(input int ix, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd = 1; addr = {ix[2:0], 1'b0};
        @(negedge clk);
        rd = 0;
        chk(req, rdata, exp);
    endtask

    task automatic engine_done(input logic [8:0] f);
        @(negedge clk);
        done_in = 1; fl_in = f;
        @(negedge clk);
        done_in = 0; fl_in = 0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog actual hung expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state, R2 holes read zero
        bus_read(0, 16'h0001, "R1 status after reset");
        bus_read(1, 16'h0080, "R1 command after reset");
        bus_read(2, 16'h0000, "R1 count after reset");
        bus_read(3, 16'h0000, "R1 address after reset");
        bus_read(4, 16'h0000, "R1 dbuf after reset");
        bus_read(6, 16'h0000, "R2 index 6 zero");
        bus_read(7, 16'h0000, "R2 index 7 zero");
        chk("R1 irq after reset", {15'd0, irq}, 16'd0);
        // R3 byte merging
        bus_write(2, 16'h1234, 0, 0);
        bus_write(2, 16'h00AB, 1, 1);
        bus_read(2, 16'hAB34, "R3 count upper byte");
        bus_write(2, 16'h77CD, 1, 0);
        bus_read(2, 16'hABCD, "R3 count lower byte");
        bus_write(3, 16'hF00F, 0, 0);
        bus_write(3, 16'h0055, 1, 0);
        bus_read(3, 16'hF055, "R3 address lower byte");
        chk("R3 eng_addr port", adr_o, 16'hF055);
        // R4 status read only
        bus_write(0, 16'hFFFF, 0, 0);
        bus_read(0, 16'h0001, "R4 status unchanged");
        // R12 data buffer
        bus_write(4, 16'h5A5A, 0, 0);
        bus_read(4, 16'h005A, "R12 dbuf 8 bits");
        bus_write(4, 16'h00FF, 1, 1);
        bus_read(4, 16'h005A, "R12 upper byte ignored");
        bus_write(4, 16'h0011, 1, 0);
        bus_read(4, 16'h0011, "R12 lower byte");
        // R11 read lines
        bus_read(5, 16'h8000, "R11 first read");
        bus_read(5, 16'h0000, "R11 second read");
        bus_read(5, 16'h8000, "R11 third read");
        // R10 enable with done set raises irq
        bus_write(1, 16'h6B7C, 0, 0);
        chk("R10 irq on enable", {15'd0, irq}, 16'd1);
        bus_read(1, 16'h6BFC, "R7 command fields, go reads 0");
        chk("R7 eng_unit", {13'd0, unit}, 16'd3);
        chk("R7 eng_dens", {14'd0, dens}, 16'd3);
        bus_write(1, 16'h0000, 0, 0);
        chk("R10 irq cleared by ie=0", {15'd0, irq}, 16'd0);
        // R7 go
        bus_write(1, 16'h0043, 0, 0);
        chk("R7 eng_go pulse", {15'd0, go}, 16'd1);
        chk("R7 eng_func", {13'd0, func}, 16'd1);
        chk("R7 irq cleared by go", {15'd0, irq}, 16'd0);
        bus_read(1, 16'h0042, "R7 done cleared");
        // R5 busy write rejected, R9 error bit
        bus_write(1, 16'h0000, 0, 0);
        bus_read(0, 16'h8000, "R5 illegal flag");
        bus_read(1, 16'h8042, "R5 R9 command kept, error set");
        // R8 completion
        engine_done(9'h004);
        chk("R8 irq on done", {15'd0, irq}, 16'd1);
        bus_read(0, 16'h8201, "R8 flags merged");
        bus_read(1, 16'h80C2, "R8 R9 done and error");
        // R6 init via upper byte write
        bus_write(1, 16'h0010, 1, 1);
        chk("R6 irq after init", {15'd0, irq}, 16'd0);
        bus_read(1, 16'h0080, "R6 command after init");
        bus_read(0, 16'h0001, "R6 status after init");
        bus_read(2, 16'h0000, "R6 count after init");
        bus_read(4, 16'h0000, "R6 dbuf after init");
        bus_read(5, 16'h8000, "R6 read lines after init");
        // go without interrupts, then enable afterwards
        bus_write(1, 16'h0005, 0, 0);
        chk("R7 second go", {15'd0, go}, 16'd1);
        chk("R7 second func", {13'd0, func}, 16'd2);
        engine_done(9'h000);
        chk("R8 no irq when disabled", {15'd0, irq}, 16'd0);
        bus_read(1, 16'h0084, "R8 done without error");
        bus_write(1, 16'h0040, 0, 0);
        chk("R10 late enable raises irq", {15'd0, irq}, 16'd1);
        bus_write(1, 16'h0000, 1, 0);
        chk("R10 byte write clears ie", {15'd0, irq}, 16'd0);
        repeat (2) @(negedge clk);
        finished = 1;
        summary();
    end

endmodule